// File: doc/BRIEF.md
# Four-Lane Serial Sample Framer

This block takes four parallel 8-bit sample words and turns them into four one-bit serial lanes. It also produces a double-data-rate data clock and a byte-rate frame clock. All of its logic runs in one fast clock domain at the serial bit rate. A one-cycle sample strobe arrives once every eight bit periods. Each strobe captures a new set of words into a fixed-latency delay line. The same strobe starts a new output byte on every lane.

The surrounding system controls four things. It picks the output coding: offset binary, or two's complement made by flipping the MSB. It can replace all lane data with a fixed alignment byte. It reports whether the external rate multiplier is locked. It can put the outputs into power-down, which appears here as a low output-enable flag.

While lock is lost, the lanes and the data clock freeze, and the rest of the interrupted byte is dropped. When lock returns, framing restarts on a sample strobe, with a minimum guard interval before the restart.

A central state machine sets the behaviour. It has five states:
- `FS_IDLE`: after reset or wake-up, waiting for a strobe.
- `FS_RUN`: framing.
- `FS_HOLD`: lock lost.
- `FS_RESYNC`: lock back, waiting for a strobe once the guard interval has passed.
- `FS_SLEEP`: power-down.

The transitions are:
- idle-start: `FS_IDLE` to `FS_RUN` on a strobe while locked.
- lock-drop: `FS_RUN` or `FS_RESYNC` to `FS_HOLD` when lock is low.
- lock-return: `FS_HOLD` to `FS_RESYNC` when lock is high.
- resync-start: `FS_RESYNC` to `FS_RUN` on a strobe after the guard interval.
- sleep-entry: any state to `FS_SLEEP` while power-down is requested.
- wake: `FS_SLEEP` to `FS_IDLE` when the request is released.

Top module: `quad_lane_framer`

## Requirements
- R1: While reset is applied, and after reset until the first sample strobe, every lane is 0, the frame clock is 0, the data clock is 0 and the output enable is 1.
- R2: Lane i serializes bits [8i+7:8i] of `sample_word`, MSB first. The lane shows a byte's MSB in the cycle after the strobe edge that loads it. It then shows one further bit per cycle, toward the LSB.
- R3: The frame clock is 1 for the first four bit periods of each byte and 0 for the last four. It rises only in the cycle after a strobe edge.
- R4: While framing, the data clock toggles on every bit-period edge, so it runs at four times the sample rate with data changing on both of its edges.
- R5: With `fmt_twos`=0 a byte is sent in offset binary, unchanged. With `fmt_twos`=1 the MSB of the byte is inverted. The select is sampled only at the strobe edge that loads a byte, so a change affects the next byte only.
- R6: With `test_pat_en`=1 at a loading strobe edge, every lane sends 11000000 for that byte, and the frame and data clocks keep their normal behaviour.
- R7: At every clock edge where lock is low, the lanes and the data clock keep their values and the frame clock is 0 afterwards. The rest of an interrupted byte is never sent.
- R8: After lock returns, the frame clock next rises in the cycle after the first strobe edge that comes at least 4 edges after the edge that saw lock high. With strobes every 8 cycles this is 4 to 11 edges later.
- R9: An edge with `pwr_down`=1 makes `lane_oe` 0 from the next cycle. An edge with `pwr_down`=0 while sleeping returns `lane_oe` to 1, and framing restarts at the next strobe.
- R10: The delay line advances on every strobe in every state. The byte loaded at strobe k always carries the word presented with strobe k-6, including after a hold or a sleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_tick | input | 1 | One-cycle sample strobe, once per eight cycles |
| sample_word | input | 32 | Four 8-bit samples, lane i in bits [8i+7:8i] |
| fmt_twos | input | 1 | 0 = offset binary, 1 = two's complement |
| test_pat_en | input | 1 | Replace lane data with the alignment byte |
| pwr_down | input | 1 | Power-down request |
| pll_locked | input | 1 | Lock indication from the rate multiplier |
| lane_data | output | 4 | Serial lane outputs |
| lane_oe | output | 1 | Output enable, low in power-down |
| dclk | output | 1 | Double-data-rate data clock |
| fclk | output | 1 | Frame clock, high over the first half of each byte |

## Verification
Each lane bit, the frame clock and the data clock are registered, so each is due in the cycle after the edge that caused it. The bench drives inputs on the falling edge, updates its own model of the requirements on the rising edge and compares every output on the next falling edge. The byte that starts at strobe k must match the word the bench drove six strobes earlier, so the bench keeps its own six-deep history of driven words. Resynchronization delay is measured in falling edges from the release of lock to the first high frame clock, which must be 5 to 12, meaning 4 to 11 edges after the edge that saw lock.

// File: rtl/framer_pkg.sv
package framer_pkg;

    typedef enum logic [2:0] {
        FS_IDLE,
        FS_RUN,
        FS_HOLD,
        FS_RESYNC,
        FS_SLEEP
    } frm_state_t;

endpackage

// File: rtl/sample_delay_line.sv
module sample_delay_line #(
    parameter int LANES    = 4,
    parameter int SAMPLE_W = 8,
    parameter int DEPTH    = 6
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        adv,
    input  logic [LANES*SAMPLE_W-1:0]   din,
    output logic [LANES*SAMPLE_W-1:0]   dout
);
    localparam int BUS_W = LANES * SAMPLE_W;

    logic [BUS_W-1:0] stage [DEPTH];

    // Oldest stage feeds the serializers; it is read before this edge's shift.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) stage[i] <= '0;
        end else if (adv) begin
            stage[0] <= din;
            for (int i = 1; i < DEPTH; i++) stage[i] <= stage[i-1];
        end
    end

    assign dout = stage[DEPTH-1];

endmodule

// File: rtl/lane_encoder.sv
module lane_encoder #(
    parameter int                    SAMPLE_W  = 8,
    parameter logic [SAMPLE_W-1:0]   TEST_WORD = 8'hC0
) (
    input  logic [SAMPLE_W-1:0] raw,
    input  logic                twos,
    input  logic                test_en,
    output logic [SAMPLE_W-1:0] coded
);
    always_comb begin
        if (test_en) begin
            coded = TEST_WORD;
        end else begin
            coded = {raw[SAMPLE_W-1] ^ twos, raw[SAMPLE_W-2:0]};
        end
    end

endmodule

// File: rtl/lane_serializer.sv
module lane_serializer #(
    parameter int SAMPLE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic                shift_en,
    input  logic [SAMPLE_W-1:0] din,
    output logic                sout
);
    logic [SAMPLE_W-1:0] shreg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg <= '0;
        end else if (load) begin
            shreg <= din;
        end else if (shift_en) begin
            shreg <= {shreg[SAMPLE_W-2:0], 1'b0};
        end
    end

    assign sout = shreg[SAMPLE_W-1];

endmodule

// File: rtl/frame_ctrl.sv
module frame_ctrl
    import framer_pkg::*;
#(
    parameter int SAMPLE_W = 8,
    parameter int GUARD    = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic lock,
    input  logic pd,
    output logic load,
    output logic shift_en,
    output logic fclk,
    output logic dclk,
    output logic oe
);
    localparam int CNT_W  = $clog2(SAMPLE_W);
    localparam int WAIT_W = $clog2(GUARD + 1);
    localparam logic [CNT_W-1:0]  HALF_BYTE = CNT_W'(SAMPLE_W / 2);
    localparam logic [WAIT_W-1:0] WAIT_MAX  = WAIT_W'(GUARD);
    localparam logic [WAIT_W-1:0] WAIT_OK   = WAIT_W'(GUARD - 1);

    frm_state_t         state, nxt;
    logic [CNT_W-1:0]   bit_cnt;
    logic [WAIT_W-1:0]  wait_cnt;
    logic               dclk_q;
    logic               guard_ok;

    assign guard_ok = (wait_cnt >= WAIT_OK);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= FS_IDLE;
        else        state <= nxt;
    end

    // Next state and per-edge strobes
    always_comb begin
        nxt      = state;
        load     = 1'b0;
        shift_en = 1'b0;
        if (pd) begin
            nxt = FS_SLEEP;
        end else begin
            unique case (state)
                FS_IDLE: begin
                    if (lock && tick) begin
                        nxt  = FS_RUN;
                        load = 1'b1;
                    end
                end
                FS_RUN: begin
                    if (!lock)     nxt      = FS_HOLD;
                    else if (tick) load     = 1'b1;
                    else           shift_en = 1'b1;
                end
                FS_HOLD: begin
                    if (lock) nxt = FS_RESYNC;
                end
                FS_RESYNC: begin
                    if (!lock) begin
                        nxt = FS_HOLD;
                    end else if (tick && guard_ok) begin
                        nxt  = FS_RUN;
                        load = 1'b1;
                    end
                end
                FS_SLEEP: nxt = FS_IDLE;
                default:  nxt = FS_IDLE;
            endcase
        end
    end

    // Bit position, DDR clock and resync guard counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt  <= '0;
            dclk_q   <= 1'b0;
            wait_cnt <= '0;
        end else begin
            if (load)          bit_cnt <= '0;
            else if (shift_en) bit_cnt <= bit_cnt + 1'b1;

            if (load || shift_en) dclk_q <= ~dclk_q;

            if (state != FS_RESYNC)     wait_cnt <= '0;
            else if (wait_cnt != WAIT_MAX) wait_cnt <= wait_cnt + 1'b1;
        end
    end

    // Outputs
    always_comb begin
        fclk = (state == FS_RUN) && (bit_cnt < HALF_BYTE);
        dclk = dclk_q;
        oe   = (state != FS_SLEEP);
    end

endmodule

// File: rtl/quad_lane_framer.sv
module quad_lane_framer #(
    parameter int                    LANES     = 4,
    parameter int                    SAMPLE_W  = 8,
    parameter int                    LATENCY   = 6,
    parameter int                    GUARD     = 4,
    parameter logic [SAMPLE_W-1:0]   TEST_WORD = 8'hC0
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       sample_tick,
    input  logic [LANES*SAMPLE_W-1:0]  sample_word,
    input  logic                       fmt_twos,
    input  logic                       test_pat_en,
    input  logic                       pwr_down,
    input  logic                       pll_locked,
    output logic [LANES-1:0]           lane_data,
    output logic                       lane_oe,
    output logic                       dclk,
    output logic                       fclk
);
    localparam int BUS_W = LANES * SAMPLE_W;

    logic [BUS_W-1:0] delayed;
    logic             load;
    logic             shift_en;

    sample_delay_line #(
        .LANES(LANES), .SAMPLE_W(SAMPLE_W), .DEPTH(LATENCY)
    ) u_delay (
        .clk(clk), .rst_n(rst_n), .adv(sample_tick),
        .din(sample_word), .dout(delayed)
    );

    frame_ctrl #(
        .SAMPLE_W(SAMPLE_W), .GUARD(GUARD)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .tick(sample_tick), .lock(pll_locked),
        .pd(pwr_down), .load(load), .shift_en(shift_en),
        .fclk(fclk), .dclk(dclk), .oe(lane_oe)
    );

    generate
        for (genvar g = 0; g < LANES; g++) begin : g_lane
            logic [SAMPLE_W-1:0] coded;

            lane_encoder #(
                .SAMPLE_W(SAMPLE_W), .TEST_WORD(TEST_WORD)
            ) u_enc (
                .raw(delayed[g*SAMPLE_W +: SAMPLE_W]), .twos(fmt_twos),
                .test_en(test_pat_en), .coded(coded)
            );

            lane_serializer #(
                .SAMPLE_W(SAMPLE_W)
            ) u_ser (
                .clk(clk), .rst_n(rst_n), .load(load), .shift_en(shift_en),
                .din(coded), .sout(lane_data[g])
            );
        end
    endgenerate

endmodule

// File: rtl/framer_checker.sv
module framer_checker #(
    parameter int LANES = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sample_tick,
    input logic             test_pat_en,
    input logic             pwr_down,
    input logic             pll_locked,
    input logic [LANES-1:0] lane_data,
    input logic             lane_oe,
    input logic             dclk,
    input logic             fclk
);
    AST_SLEEP_OE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_down |=> !lane_oe);  // R9

    AST_WAKE_OE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (!pwr_down && !lane_oe) |=> lane_oe);  // R9

    AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (!pll_locked && !pwr_down) |=> ($stable(lane_data) && $stable(dclk)));  // R7

    AST_FCLK_LOW_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        !pll_locked |=> !fclk);  // R7

    AST_DCLK_DDR_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (fclk && pll_locked && !pwr_down) |=> (dclk != $past(dclk)));  // R4

    AST_FCLK_RISE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fclk) |-> $past(sample_tick));  // R3

    AST_PATTERN_LEAD_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(fclk) && $past(test_pat_en)) |-> (&lane_data));  // R6

endmodule

bind quad_lane_framer framer_checker #(.LANES(LANES)) u_chk (
    .clk(clk), .rst_n(rst_n), .sample_tick(sample_tick),
    .test_pat_en(test_pat_en), .pwr_down(pwr_down), .pll_locked(pll_locked),
    .lane_data(lane_data), .lane_oe(lane_oe), .dclk(dclk), .fclk(fclk)
);

// File: tb/quad_lane_framer_tb_top.sv
`timescale 1ns/1ps
module quad_lane_framer_tb_top;

    localparam int ST_IDLE = 0, ST_RUN = 1, ST_HOLD = 2, ST_RESYNC = 3, ST_SLEEP = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sample_tick = 1'b0;
    logic [31:0] sample_word = '0;
    logic        fmt_twos = 1'b0;
    logic        test_pat_en = 1'b0;
    logic        pwr_down = 1'b0;
    logic        pll_locked = 1'b1;
    logic [3:0]  lane_data;
    logic        lane_oe;
    logic        dclk;
    logic        fclk;

    int    n_checks = 0;
    int    n_fail = 0;
    int    cycles = 0;
    string cur_req = "R1";

    // bench model state
    int          mstate = ST_IDLE;
    int          mbit = 0;
    int          mwait = 0;
    logic        mdclk = 1'b0;
    logic [7:0]  mbyte [4];
    logic [31:0] hist [6];
    logic [31:0] ld_word;
    logic [3:0]  elane = '0;
    bit          do_load;

    int tcnt = 0;
    int tick_idx = 0;

    always #2.5 clk = ~clk;

    quad_lane_framer dut_i (
        .clk(clk), .rst_n(rst_n), .sample_tick(sample_tick),
        .sample_word(sample_word), .fmt_twos(fmt_twos),
        .test_pat_en(test_pat_en), .pwr_down(pwr_down),
        .pll_locked(pll_locked), .lane_data(lane_data), .lane_oe(lane_oe),
        .dclk(dclk), .fclk(fclk)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h t=%0t", req, what, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    endtask

    function automatic logic [31:0] gen_word(input int n);
        logic [31:0] w;
        for (int i = 0; i < 4; i++) w[8*i +: 8] = 8'((n + i * 67) & 255);
        return w;
    endfunction

    // Reference model built from the requirements
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mstate = ST_IDLE; mbit = 0; mwait = 0; mdclk = 1'b0; elane = '0;
            for (int i = 0; i < 6; i++) hist[i] = '0;
            for (int i = 0; i < 4; i++) mbyte[i] = '0;
        end else begin
            ld_word = hist[5];
            if (sample_tick) begin
                for (int i = 5; i > 0; i--) hist[i] = hist[i-1];
                hist[0] = sample_word;
            end
            do_load = 1'b0;
            if (pwr_down) begin
                mstate = ST_SLEEP;
            end else begin
                case (mstate)
                    ST_IDLE:   if (pll_locked && sample_tick) do_load = 1'b1;
                    ST_RUN: begin
                        if (!pll_locked) mstate = ST_HOLD;
                        else if (sample_tick) do_load = 1'b1;
                        else begin mbit = (mbit + 1) & 7; mdclk = ~mdclk; end
                    end
                    ST_HOLD:   if (pll_locked) begin mstate = ST_RESYNC; mwait = 0; end
                    ST_RESYNC: begin
                        if (!pll_locked) mstate = ST_HOLD;
                        else if (sample_tick && mwait >= 3) do_load = 1'b1;
                        else mwait++;
                    end
                    default:   mstate = ST_IDLE;
                endcase
            end
            if (do_load) begin
                for (int i = 0; i < 4; i++)
                    mbyte[i] = test_pat_en ? 8'hC0 : (ld_word[8*i +: 8] ^ {fmt_twos, 7'b0});
                mbit = 0; mdclk = ~mdclk; mstate = ST_RUN;
            end
            if (mstate == ST_RUN)
                for (int i = 0; i < 4; i++) elane[i] = mbyte[i][7 - mbit];
        end
    end

    // Compare on the falling edge, then drive the strobe and words
    always @(negedge clk) begin
        if (rst_n) begin
            check(lane_data == elane, cur_req, "lane_data", int'(lane_data), int'(elane));
            check(fclk == (mstate == ST_RUN && mbit < 4), "R3", "fclk",
                  int'(fclk), int'(mstate == ST_RUN && mbit < 4));
            check(dclk == mdclk, "R4", "dclk", int'(dclk), int'(mdclk));
            check(lane_oe == (mstate != ST_SLEEP), "R9", "lane_oe",
                  int'(lane_oe), int'(mstate != ST_SLEEP));
            tcnt = (tcnt + 1) & 7;
            sample_tick = (tcnt == 7);
            if (sample_tick) begin
                sample_word = gen_word(tick_idx);
                tick_idx++;
            end
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 200000) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog actual=%0d expected<=200000", cycles);
            finish_run();
        end
    end

    initial begin
        int c;
        // R1: reset values
        repeat (5) @(negedge clk);
        check(lane_data == 4'h0, "R1", "lane_data in reset", int'(lane_data), 0);
        check(fclk == 1'b0, "R1", "fclk in reset", int'(fclk), 0);
        check(dclk == 1'b0, "R1", "dclk in reset", int'(dclk), 0);
        check(lane_oe == 1'b1, "R1", "lane_oe in reset", int'(lane_oe), 1);
        rst_n = 1'b1;
        cur_req = "R1";
        repeat (6) @(negedge clk);
        check(fclk == 1'b0 && lane_data == 4'h0, "R1", "idle before first strobe",
              int'({fclk, lane_data}), 0);

        // R2: all 256 codes on every lane, offset binary
        cur_req = "R2";
        repeat (262 * 8) @(negedge clk);

        // R5: two's complement sweep, then mid-byte toggles of the select
        cur_req = "R5";
        fmt_twos = 1'b1;
        repeat (260 * 8) @(negedge clk);
        for (int k = 0; k < 24; k++) begin
            repeat (3 + (k % 7)) @(negedge clk);
            fmt_twos = ~fmt_twos;
        end
        fmt_twos = 1'b0;
        repeat (16) @(negedge clk);

        // R6: alignment pattern on all lanes
        cur_req = "R6";
        test_pat_en = 1'b1;
        repeat (20 * 8) @(negedge clk);
        test_pat_en = 1'b0;
        repeat (16) @(negedge clk);

        // R7 / R8 / R10: lock loss at every bit offset with several durations
        for (int off = 0; off < 8; off++) begin
            for (int d = 0; d < 4; d++) begin
                int dur;
                dur = (d == 0) ? 1 : (d == 1) ? 3 : (d == 2) ? 9 : 20;
                cur_req = "R10";
                c = 0;
                while (!(mstate == ST_RUN && mbit == 0) && c < 40) begin
                    @(negedge clk);
                    c++;
                end
                repeat (off) @(negedge clk);
                cur_req = "R7";
                pll_locked = 1'b0;
                repeat (dur) @(negedge clk);
                pll_locked = 1'b1;
                c = 0;
                while (c < 40) begin
                    @(negedge clk);
                    c++;
                    if (fclk) break;
                end
                check(c >= 5 && c <= 12, "R8", "resync delay (falling edges)", c, 5);
                cur_req = "R10";
                repeat (3 * 8) @(negedge clk);
            end
        end

        // R9: power-down at every offset, then recovery
        for (int off = 0; off < 8; off++) begin
            repeat (off + 8) @(negedge clk);
            cur_req = "R9";
            pwr_down = 1'b1;
            @(negedge clk);
            check(lane_oe == 1'b0, "R9", "lane_oe in power-down", int'(lane_oe), 0);
            repeat (10 + off) @(negedge clk);
            pwr_down = 1'b0;
            @(negedge clk);
            check(lane_oe == 1'b1, "R9", "lane_oe after release", int'(lane_oe), 1);
            cur_req = "R10";
            repeat (3 * 8) @(negedge clk);
        end

        repeat (8) @(negedge clk);
        finish_run();
    end

endmodule